// File: doc/BRIEF.md
# Scaler Kernel Step Sequencer

This block sequences one axis of a polyphase image scaler. A chip carries two copies of it, one for the vertical axis and one for the horizontal axis. Each copy has its own enable input. Software sets two values through a small register write port:

- **Kernel width**, from 1 to 8. It is stored as width minus one.
- **Consumption mask**, 8 bits wide.

A `start` pulse runs one batch. The batch walks a step index from 0 up to width-1. Every step hands one output pixel to the sink. When the mask bit at the current index is set, the step first takes one new pixel from the input source. The number of input pixels used per batch is therefore the population count of the mask below the width. The number of outputs is always the width.

The block drives both pixel handshakes but carries no pixel data. The input side is a valid/ready pair: `in_ready` is asserted by the block, and a pixel is taken on any edge where `in_valid` and `in_ready` are both high. The output side is the mirror: `out_valid` is asserted by the block and completes on an edge where `out_ready` is also high.

Back-pressure works on both sides:

- Once `out_valid` rises, it stays high until it is accepted.
- Once `in_ready` rises, it stays high until a pixel arrives.
- A step that owes a read never shows `out_valid` before that read completes.
- The two strobes are never high in the same cycle.

When the last output is accepted, the index returns to 0 and `batch_done` pulses for one cycle.

Top module: `kseq_top`

## Requirements
- R1: After reset, `in_ready`, `out_valid`, `batch_done` and `busy` are all 0. The registers reset to width 1 and an all-zero mask.
- R2: A write with `cfg_addr`=0 stores `cfg_wdata[2:0]` as width minus one. A batch then completes exactly width output handshakes.
- R3: A write with `cfg_addr`=1 stores `cfg_wdata[7:0]` as the mask, and bits 31..8 are dropped. Step i raises `in_ready` if and only if mask bit i is set.
- R4: Mask bits at an index equal to or above the width have no effect. Input handshakes per batch equal the count of set bits in mask[width-1:0].
- R5: In a step with a read, the input handshake completes before `out_valid` of that step rises. `in_ready` and `out_valid` are never high together.
- R6: `out_valid` stays high while `out_ready` is low, and `in_ready` stays high while `in_valid` is low. A stall therefore only delays the step.
- R7: `batch_done` is high for exactly the one cycle after the last output handshake. `busy` is low in that cycle.
- R8: Width and mask are captured when a batch starts. A register write issued during a batch, or in the same cycle as the accepted `start`, takes effect from the next batch.
- R9: `start` is ignored while `busy` is high or while `en` is low.
- R10: A `start` in the cycle where `batch_done` is high begins the next batch at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Axis enable; gates acceptance of `start` |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Register select: 0 width-1, 1 mask |
| cfg_wdata | input | 32 | Register write data |
| start | input | 1 | Begin one batch when idle and enabled |
| in_valid | input | 1 | Input source has a pixel |
| in_ready | output | 1 | Block takes an input pixel this step |
| out_valid | output | 1 | Block issues an output pixel write |
| out_ready | input | 1 | Output sink accepts the write |
| batch_done | output | 1 | One-cycle pulse after a batch ends |
| busy | output | 1 | A batch is in progress |

## Verification
Two events can fall on the same edge: the end of one batch and the acceptance of the next `start`. The register file can also be written on the very edge at which a batch samples it. The bench provokes the first by holding `start` high in the `batch_done` cycle. It then expects the next batch's first handshake strobe in the following cycle, with no idle gap. It provokes the second by writing a new width alongside the `start` pulse, and judges from the handshake trace that the old width governed that batch and the new one governed the next.

// File: rtl/kseq_pkg.sv
`timescale 1ns/1ps
package kseq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2
  } phase_t;

  localparam int unsigned REG_WIDTH = 1'b0;
  localparam int unsigned REG_MASK  = 1'b1;
endpackage

// File: rtl/kseq_cfg.sv
`timescale 1ns/1ps
module kseq_cfg #(
  parameter int MAX_W  = 8,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [IDX_W-1:0]  w_m1,
  output logic [MAX_W-1:0]  mask
);
  // Each mask bit is its own enable-gated flop; upper data bits never reach them.
  logic mask_we;
  assign mask_we = we && (addr == 1'b1);

  for (genvar b = 0; b < MAX_W; b++) begin : g_mask
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask[b] <= 1'b0;
      else if (mask_we) mask[b] <= wdata[b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         w_m1 <= '0;
    else if (we && (addr == 1'b0))      w_m1 <= wdata[IDX_W-1:0];
  end
endmodule

// File: rtl/kseq_step.sv
`timescale 1ns/1ps
module kseq_step
  import kseq_pkg::*;
#(
  parameter int MAX_W = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [IDX_W-1:0] w_m1_in,
  input  logic [MAX_W-1:0] mask_in,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             done,
  output logic             busy
);
  phase_t           ph;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] idx_nx;
  logic [IDX_W-1:0] act_w;
  logic [MAX_W-1:0] act_mask;
  logic             last;

  assign idx_nx = idx + 1'b1;
  assign last   = (idx == act_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      idx      <= '0;
      act_w    <= '0;
      act_mask <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (ph)
        PH_IDLE: begin
          if (go) begin
            act_w    <= w_m1_in;
            act_mask <= mask_in;
            idx      <= '0;
            ph       <= mask_in[0] ? PH_READ : PH_WRITE;
          end
        end
        PH_READ: begin
          if (in_valid) ph <= PH_WRITE;
        end
        PH_WRITE: begin
          if (out_ready) begin
            if (last) begin
              idx  <= '0;
              ph   <= PH_IDLE;
              done <= 1'b1;
            end else begin
              idx <= idx_nx;
              ph  <= act_mask[idx_nx] ? PH_READ : PH_WRITE;
            end
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign in_ready  = (ph == PH_READ);
  assign out_valid = (ph == PH_WRITE);
  assign busy      = (ph != PH_IDLE);
endmodule

// File: rtl/kseq_top.sv
`timescale 1ns/1ps
module kseq_top #(
  parameter int MAX_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              cfg_we,
  input  logic              cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              start,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              batch_done,
  output logic              busy
);
  localparam int IDX_W = (MAX_W > 1) ? $clog2(MAX_W) : 1;

  logic [IDX_W-1:0] w_m1;
  logic [MAX_W-1:0] mask;
  logic             go;

  assign go = start && en && !busy;

  kseq_cfg #(.MAX_W(MAX_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .w_m1  (w_m1),
    .mask  (mask)
  );

  kseq_step #(.MAX_W(MAX_W), .IDX_W(IDX_W)) u_step (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .w_m1_in   (w_m1),
    .mask_in   (mask),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .done      (batch_done),
    .busy      (busy)
  );
endmodule

// File: rtl/kseq_chk.sv
`timescale 1ns/1ps
module kseq_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic start,
  input logic in_valid,
  input logic in_ready,
  input logic out_valid,
  input logic out_ready,
  input logic batch_done,
  input logic busy
);
  // R5: read strobe and write strobe never overlap
  a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  // R6: an unaccepted output write is held
  a_r6_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);

  // R6: an unserved input request is held
  a_r6_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> in_ready);

  // R7: done is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    batch_done |=> !batch_done);

  // R7: done only follows an accepted output write
  a_r7_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(batch_done) |-> $past(out_valid && out_ready));

  // R7: block is idle while done is shown
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    batch_done |-> !busy);

  // R9: without enable an idle block stays idle
  a_r9_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !busy) |=> !busy);
endmodule

bind kseq_top kseq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .start      (start),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .batch_done (batch_done),
  .busy       (busy)
);

// File: tb/sim_kseq_top.sv
`timescale 1ns/1ps
module sim_kseq_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_addr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        start = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic        batch_done;
  logic        busy;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  kseq_top u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .start(start), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .batch_done(batch_done), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Trace codes: 1 = input handshake, 2 = output handshake.
  // mode 0: partners always ready; mode 1: partners stall every third cycle.
  task automatic run_batch(input int exp_w, input logic [7:0] exp_mask, input int mode,
                           input int wr_at, input logic wr_addr, input logic [31:0] wr_data,
                           input int restart_at, input bit pre, input bit chain,
                           input string tag);
    int ev[64];
    int exp_ev[64];
    int n = 0;
    int ne = 0;
    int writes = 0;
    int k = 0;
    for (int i = 0; i < exp_w; i++) begin
      if (exp_mask[i]) begin exp_ev[ne] = 1; ne++; end
      exp_ev[ne] = 2; ne++;
    end
    while (writes < exp_w && k < 200) begin
      @(negedge clk);
      start    = ((k == 0) && !pre) || (k == restart_at);
      cfg_we   = (k == wr_at);
      cfg_addr = wr_addr;
      cfg_wdata = wr_data;
      in_valid  = (mode == 0) || ((k % 3) != 1);
      out_ready = (mode == 0) || ((k % 3) != 2);
      #1;
      if (k == 0 && pre) chk(busy === 1'b1, {tag, " R10 busy at chained start"}, busy, 1);
      if (in_ready && out_valid) chk(1'b0, {tag, " R5 strobes overlap"}, 1, 0);
      if (in_ready && in_valid && n < 64) begin ev[n] = 1; n++; end
      if (out_valid && out_ready && n < 64) begin ev[n] = 2; n++; writes++; end
      k++;
    end
    @(negedge clk);
    start = chain; cfg_we = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    #1;
    chk(batch_done === 1'b1 && busy === 1'b0, {tag, " R7 done pulse and idle"},
        {batch_done, busy}, 2);
    chk(n == ne, {tag, " R2/R4 handshake count"}, n, ne);
    begin
      bit same = (n == ne);
      for (int i = 0; i < ne && i < n; i++) if (ev[i] != exp_ev[i]) same = 1'b0;
      chk(same, {tag, " R3/R5 handshake order"}, n, ne);
    end
    if (!chain) begin
      @(negedge clk);
      start = 1'b0;
      #1;
      chk(batch_done === 1'b0, {tag, " R7 done lasts one cycle"}, batch_done, 0);
    end
  endtask

  task automatic t_reset();
    #1;
    chk(in_ready === 1'b0 && out_valid === 1'b0 && batch_done === 1'b0 && busy === 1'b0,
        "R1 outputs low in reset", {in_ready, out_valid, batch_done, busy}, 0);
  endtask

  task automatic t_default();
    // R1: default width 1, empty mask -> one write, no read
    run_batch(1, 8'h00, 0, -1, 1'b0, 0, -1, 1'b0, 1'b0, "default R1");
  endtask

  task automatic t_full_mask();
    cfg_write(1'b0, 32'd7);
    cfg_write(1'b1, 32'hFF);
    run_batch(8, 8'hFF, 0, -1, 1'b0, 0, -1, 1'b0, 1'b0, "w8 full R2");
  endtask

  task automatic t_mask_beyond_width();
    // R3 upper data dropped, R4 bits 5 and 7 beyond width 5
    cfg_write(1'b0, 32'd4);
    cfg_write(1'b1, 32'hFFFF_FFA5);
    run_batch(5, 8'h05, 1, -1, 1'b0, 0, -1, 1'b0, 1'b0, "w5 mask R4");
  endtask

  task automatic t_width_upper_bits();
    // R2: only bits 2..0 of the width data are stored
    cfg_write(1'b0, 32'hFFFF_FFF3);
    cfg_write(1'b1, 32'h0000_0012);
    run_batch(4, 8'h12, 1, -1, 1'b0, 0, -1, 1'b0, 1'b0, "w4 R2");
  endtask

  task automatic t_mid_batch_write_and_restart();
    // R8 write during batch, R9 start while busy ignored
    cfg_write(1'b0, 32'd5);
    cfg_write(1'b1, 32'h2C);
    run_batch(6, 8'h2C, 0, 3, 1'b0, 32'd1, 4, 1'b0, 1'b0, "mid R8 R9");
    run_batch(2, 8'h2C, 0, -1, 1'b0, 0, -1, 1'b0, 1'b0, "after R8");
  endtask

  task automatic t_write_with_start();
    // R8: write on the start cycle is not seen by that batch
    run_batch(2, 8'h2C, 0, 0, 1'b0, 32'd2, -1, 1'b0, 1'b0, "same-cycle R8");
    run_batch(3, 8'h2C, 0, -1, 1'b0, 0, -1, 1'b0, 1'b0, "next R8");
  endtask

  task automatic t_chain();
    // R10: start held during done starts the next batch immediately
    cfg_write(1'b0, 32'd1);
    cfg_write(1'b1, 32'h01);
    run_batch(2, 8'h01, 0, -1, 1'b0, 0, -1, 1'b0, 1'b1, "chain1 R10");
    run_batch(2, 8'h01, 1, -1, 1'b0, 0, -1, 1'b1, 1'b0, "chain2 R10");
  endtask

  task automatic t_enable_low();
    en = 1'b0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1;
    chk(busy === 1'b0 && in_ready === 1'b0 && out_valid === 1'b0,
        "R9 start ignored with en low", {busy, in_ready, out_valid}, 0);
    repeat (3) @(negedge clk);
    #1;
    chk(busy === 1'b0, "R9 still idle", busy, 0);
    en = 1'b1;
  endtask

  initial begin
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    en = 1'b1;
    t_default();
    t_full_mask();
    t_mask_beyond_width();
    t_width_upper_bits();
    t_mid_batch_write_and_restart();
    t_write_with_start();
    t_chain();
    t_enable_low();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule